// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Absolute Compare

This block is a watchdog that watches a free-running 64-bit system count supplied from outside. Rather than counting down, it holds an absolute 64-bit deadline. A refresh, a change of the timeout offset, or switching the watchdog on sets that deadline to the present count plus a 32-bit offset. When the count reaches the deadline for the first time, the block raises an interrupt (stage one) and sets a new deadline one offset later. If the count reaches that second deadline with no refresh in between, the block raises a reset request (stage two). Each stage therefore takes one offset, so the full timeout before reset is two offsets.

Software reaches the block through a single 32-bit register port that has two window selects. The refresh window contains only the kick register and an identification word. The control window contains the enable and status word, the offset, the two halves of the deadline, and a second identification word. Reads are combinational on the selected address. Writes take effect at the next rising clock edge.

Top module: `gwd_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the enable, both status bits, the offset and the 64-bit deadline are all zero, and both outputs are low.
- R2: A write of any data to refresh-window address 0x000 loads the deadline with the present count plus the zero-extended offset and clears both status bits.
- R3: Control-window address 0x000 reads back enable in bit 0, stage-one status in bit 1 and stage-two status in bit 2, with zeros above. A write there updates only the enable from data bit 0, so writing zero disables the watchdog, and the written status bits have no effect.
- R4: A control write that takes enable from 0 to 1 loads the deadline with count plus offset and clears both status bits.
- R5: A write to control address 0x008 stores the 32-bit offset, loads the deadline with count plus the new offset, and clears both status bits.
- R6: Control addresses 0x010 and 0x014 read and write the low and high 32-bit halves of the deadline.
- R7: While enabled, with no register write in that cycle, a count greater than or equal to the deadline while stage-one status is clear sets stage-one status and reloads the deadline with count plus offset.
- R8: While enabled, with no register write in that cycle, a count greater than or equal to the deadline while stage-one status is set sets stage-two status. Stage-two status then holds until a refresh, an offset write or an enable rise. Stage-two status is never set while stage-one status is clear.
- R9: While disabled, no expiry is detected and both status bits remain unchanged.
- R10: ws0_irq equals the stage-one status bit and ws1_rst equals the stage-two status bit at all times.
- R11: Address 0xFCC returns the parameter CTRL_ID in the control window and REFR_ID in the refresh window.
- R12: Reads of any other address, and all reads with no window selected, return zero. Writes to those addresses change no state.
- R13: A register write to any implemented writable location takes effect in that cycle and suppresses expiry detection for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_count | input | 64 | Free-running system count |
| bus_ctrl_sel | input | 1 | Access targets the control window (takes precedence if both selects are high) |
| bus_refr_sel | input | 1 | Access targets the refresh window |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ws0_irq | output | 1 | Stage-one interrupt |
| ws1_rst | output | 1 | Stage-two reset request |

## Verification
The deadline logic is driven with a count that mostly advances by one per cycle and sometimes jumps forward. Small offsets make both stages fire repeatedly, which separates a correct stage-one reload from a missing one. Random refreshes, offset writes, enable toggles and direct deadline writes are mixed in, and some of them land on the exact cycle an expiry would occur. This shows whether writes take priority over expiry. Directed cases cover the state after reset, deadline read-back, identification words, unmapped accesses, and a count near the 64-bit wrap, which distinguishes a wrapping deadline sum from a saturating one.

// File: rtl/gwd_pkg.sv
// Package: shared constants and the write-strobe bundle for the watchdog.
// Assumes a 32-bit data path and 12-bit byte offsets within each window.
package gwd_pkg;
    localparam int GWD_DATA_W = 32;
    localparam int GWD_ADDR_W = 12;

    // Byte offsets inside the control window
    localparam logic [GWD_ADDR_W-1:0] A_CTRL   = 12'h000;
    localparam logic [GWD_ADDR_W-1:0] A_OFS    = 12'h008;
    localparam logic [GWD_ADDR_W-1:0] A_CMP_LO = 12'h010;
    localparam logic [GWD_ADDR_W-1:0] A_CMP_HI = 12'h014;
    // Byte offsets shared by both windows
    localparam logic [GWD_ADDR_W-1:0] A_KICK   = 12'h000;
    localparam logic [GWD_ADDR_W-1:0] A_IDENT  = 12'hFCC;

    // Control word bit positions
    localparam int B_EN  = 0;
    localparam int B_WS0 = 1;
    localparam int B_WS1 = 2;

    // One-cycle write strobes from the decoder to the core
    typedef struct packed {
        logic                  kick;
        logic                  ctrl;
        logic                  ofs;
        logic                  cmp_lo;
        logic                  cmp_hi;
        logic [GWD_DATA_W-1:0] data;
    } gwd_wr_t;
endpackage

// File: rtl/gwd_decode.sv
// Module: address decoder and read-back multiplexer for both register windows.
// Produces one-cycle write strobes and combinational read data from the core state.
// Assumes at most one window select is high at a time; the control window wins otherwise.
module gwd_decode
    import gwd_pkg::*;
#(
    parameter int                DATA_W  = GWD_DATA_W,
    parameter int                ADDR_W  = GWD_ADDR_W,
    parameter int                CNT_W   = 2 * GWD_DATA_W,
    parameter logic [DATA_W-1:0] CTRL_ID = 32'h0A1D_5701,
    parameter logic [DATA_W-1:0] REFR_ID = 32'h0A1D_5702
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_sel,
    input  logic              refr_sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              st_en,
    input  logic              st_ws0,
    input  logic              st_ws1,
    input  logic [DATA_W-1:0] st_ofs,
    input  logic [CNT_W-1:0]  st_cmp,
    output gwd_wr_t           wr,
    output logic [DATA_W-1:0] rdata
);
    localparam int HALF = CNT_W / 2;

    logic use_ctrl, use_refr, mapped;

    // Resolve which window this access targets
    always_comb begin
        use_ctrl = ctrl_sel;
        use_refr = refr_sel && !ctrl_sel;
    end

    // Write strobes: one per writable location
    always_comb begin
        wr        = '0;
        wr.data   = wdata;
        wr.kick   = use_refr && we && (addr == A_KICK);
        wr.ctrl   = use_ctrl && we && (addr == A_CTRL);
        wr.ofs    = use_ctrl && we && (addr == A_OFS);
        wr.cmp_lo = use_ctrl && we && (addr == A_CMP_LO);
        wr.cmp_hi = use_ctrl && we && (addr == A_CMP_HI);
    end

    // Read-back multiplexer; unmapped offsets return zero
    always_comb begin
        rdata  = '0;
        mapped = 1'b0;
        if (use_ctrl) begin
            unique case (addr)
                A_CTRL: begin
                    rdata[B_EN]  = st_en;
                    rdata[B_WS0] = st_ws0;
                    rdata[B_WS1] = st_ws1;
                    mapped       = 1'b1;
                end
                A_OFS:    begin rdata = st_ofs;             mapped = 1'b1; end
                A_CMP_LO: begin rdata = st_cmp[HALF-1:0];   mapped = 1'b1; end
                A_CMP_HI: begin rdata = st_cmp[CNT_W-1:HALF]; mapped = 1'b1; end
                A_IDENT:  begin rdata = CTRL_ID;            mapped = 1'b1; end
                default:  begin rdata = '0;                 mapped = 1'b0; end
            endcase
        end else if (use_refr) begin
            if (addr == A_IDENT) begin
                rdata  = REFR_ID;
                mapped = 1'b1;
            end
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !mapped) |-> (rdata == '0)) else $error("unmapped read nonzero"); // R12
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr.kick, wr.ctrl, wr.ofs, wr.cmp_lo, wr.cmp_hi})) else $error("multiple strobes"); // R13
endmodule

// File: rtl/gwd_core.sv
// Module: watchdog state: enable, two status stages, offset and 64-bit deadline.
// Applies register writes, reloads the deadline, and detects expiry against the count.
// Assumes write strobes are one-hot; any write suppresses expiry detection for that cycle.
module gwd_core
    import gwd_pkg::*;
#(
    parameter int DATA_W = GWD_DATA_W,
    parameter int CNT_W  = 2 * GWD_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  gwd_wr_t           wr,
    output logic              en,
    output logic              ws0,
    output logic              ws1,
    output logic [DATA_W-1:0] ofs,
    output logic [CNT_W-1:0]  cmp
);
    localparam int HALF = CNT_W / 2;

    logic              reload, any_wr, reached, expire;
    logic [DATA_W-1:0] ofs_next;
    logic [CNT_W-1:0]  deadline;

    // Classify this cycle: reload event, any write, and expiry
    always_comb begin
        reload   = wr.kick || wr.ofs || (wr.ctrl && !en && wr.data[B_EN]);
        any_wr   = wr.kick || wr.ctrl || wr.ofs || wr.cmp_lo || wr.cmp_hi;
        reached  = (count >= cmp);
        expire   = en && !any_wr && reached;
        ofs_next = wr.ofs ? wr.data : ofs;
        deadline = count + CNT_W'(ofs_next);
    end

    // State update: writes first, then expiry escalation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            ws0 <= 1'b0;
            ws1 <= 1'b0;
            ofs <= '0;
            cmp <= '0;
        end else begin
            if (wr.ofs)  ofs <= wr.data;
            if (wr.ctrl) en  <= wr.data[B_EN];
            if (reload) begin
                cmp <= deadline;
                ws0 <= 1'b0;
                ws1 <= 1'b0;
            end else if (wr.cmp_lo) begin
                cmp[HALF-1:0] <= wr.data;
            end else if (wr.cmp_hi) begin
                cmp[CNT_W-1:HALF] <= wr.data;
            end else if (expire) begin
                if (!ws0) begin
                    ws0 <= 1'b1;
                    cmp <= deadline;
                end else begin
                    ws1 <= 1'b1;
                end
            end
        end
    end

    AST_WS1_AFTER_WS0: assert property (@(posedge clk) disable iff (!rst_n)
        ws1 |-> ws0) else $error("stage two without stage one"); // R8
    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.kick || wr.ofs) |=> (!ws0 && !ws1)) else $error("reload left status"); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr.kick && !wr.ofs && !wr.ctrl) |=> ($stable(ws0) && $stable(ws1))) else $error("status moved while off"); // R9
    AST_FIRST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ws0 && !any_wr && (count >= cmp)) |=> (ws0 && !ws1 && cmp == $past(count) + CNT_W'($past(ofs)))) else $error("stage one reload wrong"); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.cmp_lo && !ws0) |=> !ws0) else $error("expiry during write"); // R13
endmodule

// File: rtl/gwd_top.sv
// Module: top of the two-stage watchdog; joins decoder and core.
// Outputs follow the status bits directly. Assumes sys_count is synchronous to clk.
module gwd_top
    import gwd_pkg::*;
#(
    parameter int                DATA_W  = GWD_DATA_W,
    parameter int                ADDR_W  = GWD_ADDR_W,
    parameter logic [DATA_W-1:0] CTRL_ID = 32'h0A1D_5701,
    parameter logic [DATA_W-1:0] REFR_ID = 32'h0A1D_5702
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   sys_count,
    input  logic                  bus_ctrl_sel,
    input  logic                  bus_refr_sel,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  ws0_irq,
    output logic                  ws1_rst
);
    localparam int CNT_W = 2 * DATA_W;

    gwd_wr_t           wr;
    logic              st_en, st_ws0, st_ws1;
    logic [DATA_W-1:0] st_ofs;
    logic [CNT_W-1:0]  st_cmp;

    gwd_decode #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .CTRL_ID(CTRL_ID), .REFR_ID(REFR_ID)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .ctrl_sel(bus_ctrl_sel), .refr_sel(bus_refr_sel), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata),
        .st_en(st_en), .st_ws0(st_ws0), .st_ws1(st_ws1),
        .st_ofs(st_ofs), .st_cmp(st_cmp),
        .wr(wr), .rdata(bus_rdata)
    );

    gwd_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .count(sys_count), .wr(wr),
        .en(st_en), .ws0(st_ws0), .ws1(st_ws1), .ofs(st_ofs), .cmp(st_cmp)
    );

    // Drive the stage outputs straight from the status bits
    always_comb begin
        ws0_irq = st_ws0;
        ws1_rst = st_ws1;
    end
endmodule

// File: tb/gwd_top_test.sv
// Bench: random register traffic mixed with directed cases, checked against a
// reference model written from the requirements.
module gwd_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = '0;
    logic        csel = 1'b0, rsel = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ws0_irq, ws1_rst;

    localparam logic [31:0] CID = 32'h0A1D_5701;
    localparam logic [31:0] RID = 32'h0A1D_5702;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;

    // model state
    logic        m_en, m_ws0, m_ws1;
    logic [31:0] m_ofs;
    logic [63:0] m_cmp;

    gwd_top #(.CTRL_ID(CID), .REFR_ID(RID)) uut (
        .clk(clk), .rst_n(rst_n), .sys_count(cnt),
        .bus_ctrl_sel(csel), .bus_refr_sel(rsel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .ws0_irq(ws0_irq), .ws1_rst(ws1_rst)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic c, input logic r, input logic [11:0] a);
        if (c) begin
            case (a)
                12'h000: return {29'd0, m_ws1, m_ws0, m_en};
                12'h008: return m_ofs;
                12'h010: return m_cmp[31:0];
                12'h014: return m_cmp[63:32];
                12'hFCC: return CID;
                default: return 32'd0;
            endcase
        end else if (r && a == 12'hFCC) return RID;
        return 32'd0;
    endfunction

    // Model step at a clock edge using the inputs present at that edge
    task automatic model_step();
        logic kick, cw, ow, lo, hi, rel, anyw;
        logic [31:0] on;
        kick = rsel && !csel && we && addr == 12'h000;
        cw = csel && we && addr == 12'h000;
        ow = csel && we && addr == 12'h008;
        lo = csel && we && addr == 12'h010;
        hi = csel && we && addr == 12'h014;
        rel  = kick || ow || (cw && !m_en && wdata[0]);
        anyw = kick || cw || ow || lo || hi;
        on = ow ? wdata : m_ofs;
        if (!rst_n) begin
            m_en = 0; m_ws0 = 0; m_ws1 = 0; m_ofs = 0; m_cmp = 0;
            return;
        end
        if (rel) begin
            m_cmp = cnt + {32'd0, on}; m_ws0 = 0; m_ws1 = 0;
        end else if (lo) m_cmp[31:0] = wdata;
        else if (hi) m_cmp[63:32] = wdata;
        else if (m_en && !anyw && cnt >= m_cmp) begin
            if (!m_ws0) begin m_ws0 = 1; m_cmp = cnt + {32'd0, m_ofs}; end
            else m_ws1 = 1;
        end
        if (ow) m_ofs = wdata;
        if (cw) m_en = wdata[0];
    endtask

    // One bus cycle: check outputs, drive, check read data, advance the edge
    task automatic cyc(input logic c, input logic r, input logic w,
                       input logic [11:0] a, input logic [31:0] d,
                       input logic [63:0] step, input string tag);
        @(negedge clk);
        chk("R10 R7 ws0_irq", {63'd0, ws0_irq}, {63'd0, m_ws0});
        chk("R8 ws1_rst", {63'd0, ws1_rst}, {63'd0, m_ws1});
        cnt = cnt + step;
        csel = c; rsel = r; we = w; addr = a; wdata = d;
        #1;
        if (!w) chk(tag, {32'd0, rdata}, {32'd0, exp_read(c, r, a)});
        @(posedge clk);
        model_step();
    endtask

    task automatic rd(input logic c, input logic [11:0] a, input string tag);
        cyc(c, !c, 1'b0, a, 32'd0, 64'd1, tag);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin @(posedge clk); wd++; end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_en = 0; m_ws0 = 0; m_ws1 = 0; m_ofs = 0; m_cmp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        chk("R1 ws0", {63'd0, ws0_irq}, 64'd0);
        chk("R1 ws1", {63'd0, ws1_rst}, 64'd0);
        rd(1, 12'h000, "R1 R3 ctrl");
        rd(1, 12'h008, "R1 ofs");
        rd(1, 12'h010, "R1 cmp lo");
        // R11: identification words
        rd(1, 12'hFCC, "R11 ctrl id");
        rd(0, 12'hFCC, "R11 refr id");
        // R6: deadline halves
        cyc(1, 0, 1, 12'h010, 32'hDEAD_BEEF, 1, "");
        cyc(1, 0, 1, 12'h014, 32'h0000_0007, 1, "");
        rd(1, 12'h010, "R6 cmp lo");
        rd(1, 12'h014, "R6 cmp hi");
        // R12: unmapped writes and reads
        cyc(1, 0, 1, 12'h00C, 32'hFFFF_FFFF, 1, "");
        cyc(0, 1, 1, 12'h008, 32'hFFFF_FFFF, 1, "");
        cyc(1, 0, 1, 12'h100, 32'h1234_5678, 1, "");
        rd(1, 12'h00C, "R12 unmapped ctrl");
        rd(0, 12'h000, "R12 refresh reads zero");
        rd(1, 12'h008, "R12 ofs untouched");
        rd(1, 12'h014, "R12 cmp untouched");
        cyc(0, 0, 0, 12'h000, 0, 1, "R12 no select");
        // R3 R9: status bits not writable; disabled holds
        cyc(1, 0, 1, 12'h000, 32'h6, 1, "");
        rd(1, 12'h000, "R3 R9 ctrl after status write");
        // R5 R4 R7 R8: escalate with small offset
        cyc(1, 0, 1, 12'h008, 32'd4, 1, "");
        cyc(1, 0, 1, 12'h000, 32'd1, 1, "");
        rd(1, 12'h010, "R4 deadline after enable");
        repeat (12) rd(1, 12'h000, "R7 R8 status");
        // R2: refresh clears
        cyc(0, 1, 1, 12'h000, 32'hA5A5_A5A5, 1, "");
        rd(1, 12'h000, "R2 status after refresh");
        rd(1, 12'h010, "R2 deadline lo");
        // R3: write zero disables
        cyc(1, 0, 1, 12'h000, 32'd0, 1, "");
        repeat (10) rd(1, 12'h000, "R3 R9 disabled");
        // Wrap of the deadline sum near the top of the count
        cnt = 64'hFFFF_FFFF_FFFF_FFF0;
        cyc(1, 0, 1, 12'h008, 32'd40, 1, "");
        cyc(1, 0, 1, 12'h000, 32'd1, 1, "");
        rd(1, 12'h014, "R4 wrapped deadline hi");
        repeat (6) rd(1, 12'h000, "R7 wrap status");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int p;
            logic [11:0] ra;
            logic [63:0] st;
            p  = $urandom_range(0, 99);
            st = ($urandom_range(0, 19) == 0) ? 64'($urandom_range(2, 30)) : 64'd1;
            case ($urandom_range(0, 6))
                0: ra = 12'h000; 1: ra = 12'h008; 2: ra = 12'h010;
                3: ra = 12'h014; 4: ra = 12'hFCC; 5: ra = 12'h004;
                default: ra = 12'h018;
            endcase
            if (p < 6)       cyc(0, 1, 1, 12'h000, $urandom, st, "");
            else if (p < 11) cyc(1, 0, 1, 12'h000, ($urandom_range(0, 3) != 0) ? {29'd0, 3'($urandom)} | 32'd1 : 32'($urandom_range(0, 6)), st, "");
            else if (p < 14) cyc(1, 0, 1, 12'h008, 32'($urandom_range(1, 30)), st, "");
            else if (p < 16) cyc(1, 0, 1, 12'h010, cnt[31:0] + 32'($urandom_range(0, 20)), st, "");
            else if (p < 17) cyc(1, 0, 1, 12'h014, cnt[63:32], st, "");
            else if (p < 19) cyc(1, 0, 1, ra == 12'h000 ? 12'h01C : 12'h0F0, $urandom, st, "");
            else if (p < 45) begin
                logic c;
                c = ($urandom_range(0, 3) != 0);
                cyc(c, !c, 0, ra, 0, st, "R3 R6 R11 R12 R13 random read");
            end else cyc(0, 0, 0, 12'h000, 0, st, "R12 idle read");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule